// File: doc/BRIEF.md
# Programmable System Tick Timer

This block is a 24-bit down-counter that sits on a simple 32-bit register bus and produces the periodic interrupt an operating system kernel uses as its scheduling tick. Software loads a reload count, clears the counter, and then enables it. The counter then decrements on every clock, or on every second clock. Each time it passes from one to zero it sets a sticky status flag and, if interrupts are enabled, raises a level interrupt request. On the following tick it restarts from the reload count. The period in ticks is the reload count plus one. For example, a 50 MHz tick and a 10 ms period need a reload count of 499999 (0x7A11F).

Software reads the flag from the control word, and the read clears it. Any write to the counter register clears both the counter and the flag. A read-only calibration word is passed through from an input port. It holds a suggested ten-millisecond count in its low 24 bits and two indicator bits at the top.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the control word, the reload register and the counter all read 0, and `irq_req` is 0.
- R2: The register offsets are control 0x10, reload 0x14, counter 0x18 and calibration 0x1C. Control bit 0 is run, bit 1 is interrupt enable and bit 2 is rate (1 = every clock, 0 = every second clock), and these bits read back as written. Reload bits 23:0 read back as written. Every other control and reload bit is ignored on write and reads 0, except control bit 16 (see R5).
- R3: While running at full rate, the counter falls by one each clock. A tick taken at 0 loads the reload count. No tick happens on the edge at which run is first written.
- R4: While running at half rate, the counter falls on every second clock only. The first such tick comes two edges after the rate bit changes to 0.
- R5: Control bit 16 is set when a tick moves the counter from 1 to 0. Any read of the control register clears it.
- R6: If a 1-to-0 tick and a control read happen in the same cycle, that read returns bit 16 as 1 and the following read also returns 1.
- R7: A write of any value to the counter register sets the counter to 0 and clears bit 16. This write takes precedence over a tick in the same cycle.
- R8: `irq_req` is a level that rises after a 1-to-0 tick only while interrupt enable is 1. It stays high until an `irq_ack` pulse clears it.
- R9: A calibration read returns `cal_word` bits 31, 30 and 23:0, with bits 29:24 reading 0. Writes to the calibration offset change nothing.
- R10: With a reload count of 0, the counter reaches 0 once, flags once and then stays at 0 without flagging again.
- R11: While run is 0 the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_re` is high, 0 otherwise |
| cal_word | input | 32 | Calibration word to present at offset 0x1C |
| irq_ack | input | 1 | Pulse that clears the interrupt request |
| irq_req | output | 1 | Level interrupt request |

## Verification
The counting path is driven with the full-rate tick, the half-rate tick and a stopped counter. The reload count is set to five, then to zero, so that a normal wrap, a reload of zero and a held value each give a different sequence of counter reads.

Counter writes are placed both before a tick and on the same edge as a tick, which shows whether the write takes precedence. Flag reads are placed both one cycle after the 1-to-0 tick and on that same edge, which shows whether the flag is lost or counted twice. The interrupt is tried with enable set and with enable cleared, so a request raised by the flag alone would be caught.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int DATA_W   = 32;
  localparam int OFF_CTRL = 'h10;
  localparam int OFF_RLD  = 'h14;
  localparam int OFF_CUR  = 'h18;
  localparam int OFF_CAL  = 'h1C;
  localparam int FLAG_BIT = 16;
  localparam logic [DATA_W-1:0] CAL_KEEP = 32'hC0FF_FFFF;

  typedef struct packed {
    logic rate_full;
    logic irq_en;
    logic run;
  } tick_ctrl_t;
endpackage

// File: rtl/tick_rate_gen.sv
module tick_rate_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rate_full,
  output logic tick
);
  logic phase_q, phase_d;

  always_comb begin
    phase_d = run & ~rate_full & ~phase_q;
    tick    = run & (rate_full | phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)           cnt_d = '0;
    else if (tick) begin
      if (cnt_q == '0)   cnt_d = reload_val;
      else               cnt_d = cnt_q - ONE;
    end
    zero_evt = tick & ~clear & (cnt_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/tick_status.sv
module tick_status (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_evt,
  input  logic irq_en,
  input  logic rd_ctrl,
  input  logic wr_cur,
  input  logic irq_ack,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d, irq_q, irq_d;

  always_comb begin
    flag_d = flag_q;
    if (wr_cur)        flag_d = 1'b0;
    else if (zero_evt) flag_d = 1'b1;
    else if (rd_ctrl)  flag_d = 1'b0;

    irq_d = irq_q;
    if (zero_evt && irq_en) irq_d = 1'b1;
    else if (irq_ack)       irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import tick_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       cal_word,
  input  logic              irq_ack,
  output logic              irq_req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(OFF_RLD);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFF_CUR);
  localparam logic [ADDR_W-1:0] A_CAL  = ADDR_W'(OFF_CAL);

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // decode
  logic wr_ctrl, wr_rld, wr_cur, rd_ctrl;
  always_comb begin
    wr_ctrl = bus_we & (bus_addr == A_CTRL);
    wr_rld  = bus_we & (bus_addr == A_RLD);
    wr_cur  = bus_we & (bus_addr == A_CUR);
    rd_ctrl = bus_re & (bus_addr == A_CTRL);
  end

  // configuration registers
  tick_ctrl_t       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] rld_q, rld_d;

  always_comb begin
    ctrl_d = ctrl_q;
    rld_d  = rld_q;
    if (wr_ctrl) ctrl_d = tick_ctrl_t'(bus_wdata[2:0]);
    if (wr_rld)  rld_d  = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      ctrl_q <= '0;
      rld_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rld_q  <= rld_d;
    end
  end

  logic             tick, zero_evt, flag_q;
  logic [CNT_W-1:0] cnt_q;

  tick_rate_gen i_rate (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .run       (ctrl_q.run),
    .rate_full (ctrl_q.rate_full),
    .tick      (tick)
  );

  tick_down_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .tick       (tick),
    .clear      (wr_cur),
    .reload_val (rld_q),
    .count      (cnt_q),
    .zero_evt   (zero_evt)
  );

  tick_status i_stat (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .zero_evt (zero_evt),
    .irq_en   (ctrl_q.irq_en),
    .rd_ctrl  (rd_ctrl),
    .wr_cur   (wr_cur),
    .irq_ack  (irq_ack),
    .flag     (flag_q),
    .irq      (irq_req)
  );

  // read mux; a flag event in the read cycle is reported at once
  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      unique case (bus_addr)
        A_CTRL: begin
          bus_rdata[2:0]      = ctrl_q;
          bus_rdata[FLAG_BIT] = flag_q | zero_evt;
        end
        A_RLD:   bus_rdata = DATA_W'(rld_q);
        A_CUR:   bus_rdata = DATA_W'(cnt_q);
        A_CAL:   bus_rdata = cal_word & CAL_KEEP;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sys_tick_timer_chk.sv
module sys_tick_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             run,
  input logic             irq_en,
  input logic             rate_full,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             irq_req,
  input logic             irq_ack,
  input logic             zero_evt,
  input logic             wr_cur,
  input logic             wr_ctrl,
  input logic             rd_ctrl
);
  assert_cur_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_cur |=> (cnt == '0) && !flag);

  assert_hold_when_stopped_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (!run && !wr_cur) |=> $stable(cnt));

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (tick && cnt != '0 && !wr_cur) |=> cnt == $past(cnt) - CNT_W'(1));

  assert_half_rate_gap_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (tick && !rate_full && !wr_ctrl) |=> !tick);

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(irq_req) |-> $past(irq_en) && $past(zero_evt));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (irq_ack && !zero_evt) |=> !irq_req);

  assert_read_clears_flag_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_ctrl && !zero_evt && !wr_cur) |=> !flag);

  assert_event_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (zero_evt && !wr_cur) |=> flag);
endmodule

bind sys_tick_timer sys_tick_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_q),
  .run       (ctrl_q.run),
  .irq_en    (ctrl_q.irq_en),
  .rate_full (ctrl_q.rate_full),
  .tick      (tick),
  .cnt       (cnt_q),
  .flag      (flag_q),
  .irq_req   (irq_req),
  .irq_ack   (irq_ack),
  .zero_evt  (zero_evt),
  .wr_cur    (wr_cur),
  .wr_ctrl   (wr_ctrl),
  .rd_ctrl   (rd_ctrl)
);

// File: tb/test_sys_tick_timer.sv
module test_sys_tick_timer;
  localparam int ADDR_W = 8;
  localparam logic [7:0] A_CTRL = 8'h10, A_RLD = 8'h14, A_CUR = 8'h18, A_CAL = 8'h1C;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2;
  localparam logic [1:0] IX = 2'd2;
  localparam logic [31:0] CAL_IN  = 32'hFF07_A11F;
  localparam logic [31:0] CAL_EXP = 32'hC007_A11F;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        ack;
    logic [1:0]  irq_exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 57;
  localparam vec_t VECS [NV] = '{
    '{OP_W, A_RLD,  32'hFF00_0005, 32'h0,       1'b0, 2'd0, 8'd2},  // 0  R2 reserved reload bits dropped
    '{OP_R, A_RLD,  32'h0,         32'h5,       1'b0, 2'd0, 8'd2},  // 1  R2
    '{OP_W, A_CUR,  32'h123,       32'h0,       1'b0, 2'd0, 8'd7},  // 2  R7
    '{OP_R, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd7},  // 3  R7
    '{OP_W, A_CTRL, 32'hFFFE_FFF8, 32'h0,       1'b0, 2'd0, 8'd2},  // 4  R2 reserved control bits
    '{OP_R, A_CTRL, 32'h0,         32'h0,       1'b0, 2'd0, 8'd2},  // 5  R2
    '{OP_W, A_CTRL, 32'h7,         32'h0,       1'b0, 2'd0, 8'd3},  // 6  R3 start, full rate, irq on
    '{OP_R, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd3},  // 7  R3 no tick on start edge
    '{OP_R, A_CUR,  32'h0,         32'h5,       1'b0, 2'd0, 8'd3},  // 8  R3 reload from zero
    '{OP_R, A_CUR,  32'h0,         32'h4,       1'b0, 2'd0, 8'd3},  // 9  R3
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd3},  // 10
    '{OP_R, A_CUR,  32'h0,         32'h2,       1'b0, 2'd0, 8'd3},  // 11 R3
    '{OP_R, A_CUR,  32'h0,         32'h1,       1'b0, 2'd0, 8'd3},  // 12 R3
    '{OP_R, A_CTRL, 32'h0,         32'h1_0007,  1'b0, 2'd1, 8'd5},  // 13 R5 flag and R8 irq up
    '{OP_R, A_CTRL, 32'h0,         32'h7,       1'b0, 2'd1, 8'd5},  // 14 R5 cleared by read
    '{OP_R, A_CUR,  32'h0,         32'h4,       1'b0, 2'd1, 8'd3},  // 15 R3 period continues
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b1, 2'd1, 8'd8},  // 16 R8 acknowledge
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd8},  // 17 R8 cleared
    '{OP_R, A_CTRL, 32'h0,         32'h1_0007,  1'b0, 2'd0, 8'd6},  // 18 R6 read on the event edge
    '{OP_R, A_CTRL, 32'h0,         32'h1_0007,  1'b0, 2'd1, 8'd6},  // 19 R6 flag kept
    '{OP_R, A_CTRL, 32'h0,         32'h7,       1'b0, 2'd1, 8'd5},  // 20 R5
    '{OP_W, A_CUR,  32'hDEAD_BEEF, 32'h0,       1'b1, 2'd1, 8'd7},  // 21 R7 write beats tick
    '{OP_R, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd7},  // 22 R7
    '{OP_R, A_CUR,  32'h0,         32'h5,       1'b0, 2'd0, 8'd3},  // 23 R3
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd8},  // 24
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd8},  // 25
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd8},  // 26
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd8},  // 27
    '{OP_W, A_CUR,  32'h55,        32'h0,       1'b0, 2'd1, 8'd8},  // 28 R8 irq up, R7 clears flag
    '{OP_R, A_CTRL, 32'h0,         32'h7,       1'b0, 2'd1, 8'd7},  // 29 R7 flag gone
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b1, 2'd1, 8'd8},  // 30 R8
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd8},  // 31 R8
    '{OP_W, A_CTRL, 32'h1,         32'h0,       1'b0, 2'd0, 8'd4},  // 32 R4 half rate, irq off
    '{OP_R, A_CUR,  32'h0,         32'h2,       1'b0, 2'd0, 8'd4},  // 33 R4
    '{OP_R, A_CUR,  32'h0,         32'h2,       1'b0, 2'd0, 8'd4},  // 34 R4
    '{OP_R, A_CUR,  32'h0,         32'h1,       1'b0, 2'd0, 8'd4},  // 35 R4
    '{OP_R, A_CUR,  32'h0,         32'h1,       1'b0, 2'd0, 8'd4},  // 36 R4
    '{OP_R, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd8},  // 37 R8 no irq when disabled
    '{OP_R, A_CTRL, 32'h0,         32'h1_0001,  1'b0, 2'd0, 8'd5},  // 38 R5
    '{OP_W, A_CTRL, 32'h0,         32'h0,       1'b0, 2'd0, 8'd11}, // 39 R11 stop
    '{OP_R, A_CUR,  32'h0,         32'h5,       1'b0, 2'd0, 8'd11}, // 40 R11
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd11}, // 41
    '{OP_R, A_CUR,  32'h0,         32'h5,       1'b0, 2'd0, 8'd11}, // 42 R11 held
    '{OP_W, A_RLD,  32'h0,         32'h0,       1'b0, 2'd0, 8'd10}, // 43 R10
    '{OP_W, A_CTRL, 32'h5,         32'h0,       1'b0, 2'd0, 8'd10}, // 44 R10 full rate, irq off
    '{OP_R, A_CUR,  32'h0,         32'h5,       1'b0, 2'd0, 8'd10}, // 45 R10
    '{OP_R, A_CUR,  32'h0,         32'h4,       1'b0, 2'd0, 8'd10}, // 46 R10
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd10}, // 47
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd10}, // 48
    '{OP_R, A_CUR,  32'h0,         32'h1,       1'b0, 2'd0, 8'd10}, // 49 R10
    '{OP_R, A_CTRL, 32'h0,         32'h1_0005,  1'b0, 2'd0, 8'd10}, // 50 R10 one flag
    '{OP_I, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd10}, // 51
    '{OP_R, A_CUR,  32'h0,         32'h0,       1'b0, 2'd0, 8'd10}, // 52 R10 stays at zero
    '{OP_R, A_CTRL, 32'h0,         32'h5,       1'b0, 2'd0, 8'd10}, // 53 R10 no second flag
    '{OP_R, A_CAL,  32'h0,         CAL_EXP,     1'b0, 2'd0, 8'd9},  // 54 R9
    '{OP_W, A_CAL,  32'h0,         32'h0,       1'b0, 2'd0, 8'd9},  // 55 R9 write ignored
    '{OP_R, A_CAL,  32'h0,         CAL_EXP,     1'b0, 2'd0, 8'd9}   // 56 R9
  };

  logic              clk, rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_we, bus_re, irq_ack, irq_req;
  logic [31:0]       bus_wdata, bus_rdata, cal_word;
  int n_chk, n_fail;
  bit done;

  sys_tick_timer i_sys_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .cal_word(cal_word), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    bus_addr  = v.addr;
    bus_wdata = v.data;
    bus_we    = (v.op == OP_W);
    bus_re    = (v.op == OP_R);
    irq_ack   = v.ack;
    #4;
    if (v.op == OP_R) check(int'(v.req), "rdata", bus_rdata, v.exp);
    if (v.irq_exp != IX) check(int'(v.req), "irq", {31'b0, irq_req}, {31'b0, v.irq_exp[0]});
    @(posedge clk); #1;
    bus_we = 1'b0; bus_re = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    run_vec('{OP_W, a, d, 32'h0, 1'b0, IX, 8'd0});
  endtask

  task automatic bus_rd_chk(input logic [7:0] a, input logic [31:0] e, input int req);
    run_vec('{OP_R, a, 32'h0, e, 1'b0, IX, 8'(req)});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    bus_addr = '0; bus_we = 1'b0; bus_re = 1'b0; bus_wdata = '0;
    irq_ack = 1'b0; cal_word = CAL_IN;
    do_reset();

    // R1 reset state
    check(1, "irq after reset", {31'b0, irq_req}, 32'h0);
    bus_rd_chk(A_CTRL, 32'h0, 1);  // R1
    bus_rd_chk(A_RLD,  32'h0, 1);  // R1
    bus_rd_chk(A_CUR,  32'h0, 1);  // R1

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R2 full 24-bit reload field
    bus_wr(A_RLD, 32'hFFFF_FFFF);
    bus_rd_chk(A_RLD, 32'h00FF_FFFF, 2);  // R2
    bus_rd_chk(8'h20, 32'h0, 2);          // R2 unmapped offset reads 0

    // R1 reset in the middle of a run with a pending interrupt
    bus_wr(A_RLD, 32'h2);
    bus_wr(A_CUR, 32'h0);
    bus_wr(A_CTRL, 32'h7);
    repeat (6) @(posedge clk);
    #1;
    check(8, "irq before reset", {31'b0, irq_req}, 32'h1);  // R8
    do_reset();
    check(1, "irq after reset", {31'b0, irq_req}, 32'h0);   // R1
    bus_rd_chk(A_CTRL, 32'h0, 1);  // R1
    bus_rd_chk(A_CUR,  32'h0, 1);  // R1

    finish_run();
  end
endmodule